// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block collects seven external level-sensitive interrupt lines, numbered 1 to 7, and one internal timer request. It runs each external line through a synchronizer. It works out each line's active polarity by itself just after reset, and gates each source with an enable bit. The highest pending level goes to the processor as a registered 3-bit priority code. Level 7 is the most urgent, and code 0 means nothing is pending.

When the processor runs an interrupt-acknowledge cycle, the block answers in the same cycle. It returns one of three responses: an autovector number, an external-vector strobe that hands the cycle to outside logic, or a spurious vector when no enabled request exists at the acknowledged level. The synchronizers hold their outputs for the whole acknowledge, so outside logic can use the acknowledge to drop its request without disturbing the priority code. A single 16-bit control register holds the enables and the autovector selects. Only supervisor-mode accesses may reach it.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x007F (bits 15..8 clear, bit 7 clear, bits 6..0 set) and `ipl_o` is 0.
- R2: A supervisor write to the control register takes effect at the next clock edge. Bit 15 enables the timer. Bit 7+k enables level k (k=1..7). Bit k-1 selects autovectoring for level k. Bit 7 always reads 0.
- R3: A user-mode access leaves the register unchanged, reads back 0 and raises `reg_berr_o` in the same cycle.
- R4: During the settle window after reset, each input's synchronized level becomes its inactive level, and the opposite level becomes its active level. Bit k-1 of `irq_pin_i` is level k.
- R5: A change on an enabled pin reaches `ipl_o` on the (SYNC_STAGES+1)-th rising edge after it, and not earlier.
- R6: `ipl_o` carries the highest level that is both active and enabled. A disabled level has no effect, and the code is 0 when nothing is pending.
- R7: The timer request counts as pending at level TIMER_LEVEL only while bit 15 is set, and it reaches `ipl_o` after one edge.
- R8: An acknowledge of a pending level whose autovector bit is set completes in the same cycle (`iack_done_o`=1) with vector VEC_BASE+level and no strobe.
- R9: An acknowledge of a pending level whose autovector bit is clear raises `iack_ext_o`, with `iack_done_o`=0 and vector 0.
- R10: An acknowledge of a level with no pending request, level 0 included, completes in the same cycle with vector VEC_BASE and no strobe.
- R11: While `iack_i` is high, pin changes do not reach `ipl_o`. After the acknowledge ends, they propagate as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| irq_pin_i | input | 7 | external interrupt lines, bit k-1 = level k |
| tmr_req_i | input | 1 | internal timer request |
| reg_sel_i | input | 1 | control register access strobe |
| reg_we_i | input | 1 | write when high, read when low |
| reg_super_i | input | 1 | access is in supervisor mode |
| reg_wdata_i | input | 16 | write data |
| reg_rdata_o | output | 16 | read data |
| reg_berr_o | output | 1 | bus error on a user-mode access |
| ipl_o | output | 3 | highest pending level, 0 = none |
| iack_i | input | 1 | acknowledge cycle in progress |
| iack_lvl_i | input | 3 | level being acknowledged |
| iack_done_o | output | 1 | zero-wait completion of the acknowledge |
| iack_ext_o | output | 1 | hand the vector fetch to external logic |
| iack_vec_o | output | 8 | vector number returned |

## Verification
The bench builds the block with SYNC_STAGES=3 and TIMER_LEVEL=4. The deeper synchronizer moves the R5 edge boundary off the default, so the check catches a stage count that is off by one. With the timer at level 4, its request competes directly with external level 4 and with lower levels. The reset pin pattern alternates high and low across the seven lines, so both polarities are learned and checked within one run.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = 3;
  localparam int REG_W   = 16;
  localparam logic [REG_W-1:0] CTRL_RST  = 16'h007F;
  localparam logic [REG_W-1:0] CTRL_MASK = 16'hFF7F;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (!freeze_i) begin
        if (STAGES > 1) chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        else            chain_q <= {STAGES{d_i[b]}};
      end
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irq_pol_learn.sv
module irq_pol_learn #(
  parameter int WIDTH  = 7,
  parameter int SETTLE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] act_o
);
  localparam int CNT_W = $clog2(SETTLE + 1) + 1;
  logic [CNT_W-1:0] cnt_q;
  logic             learned_q;
  logic [WIDTH-1:0] idle_q;

  // wait for the synchronizers to fill, then capture the idle level once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      learned_q <= 1'b0;
      idle_q    <= '0;
    end else if (!learned_q) begin
      if (cnt_q == CNT_W'(SETTLE)) begin
        idle_q    <= sync_i;
        learned_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_o = learned_q ? (sync_i ^ idle_q) : '0;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import lvl_irq_pkg::*;
(
  input  logic [NUM_LVL:0]   req_i,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int k = 1; k <= NUM_LVL; k++)
      if (req_i[k]) lvl_o = LVL_W'(k);
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int TIMER_LEVEL = 6,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] irq_pin_i,
  input  logic               tmr_req_i,
  input  logic               reg_sel_i,
  input  logic               reg_we_i,
  input  logic               reg_super_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               reg_berr_o,
  output logic [LVL_W-1:0]   ipl_o,
  input  logic               iack_i,
  input  logic [LVL_W-1:0]   iack_lvl_i,
  output logic               iack_done_o,
  output logic               iack_ext_o,
  output logic [7:0]         iack_vec_o
);
  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_LVL-1:0] sync_q;
  logic [NUM_LVL-1:0] act;
  logic [NUM_LVL:0]   pend_x;
  logic [NUM_LVL:0]   avec_x;
  logic [LVL_W-1:0]   ipl_d, ipl_q;
  logic               hit, av;

  irq_sync_bank #(.WIDTH(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .freeze_i(iack_i), .d_i(irq_pin_i), .q_o(sync_q)
  );

  irq_pol_learn #(.WIDTH(NUM_LVL), .SETTLE(SYNC_STAGES)) u_pol (
    .clk_i, .rst_ni, .sync_i(sync_q), .act_o(act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (reg_sel_i && reg_we_i && reg_super_i) ctrl_q <= reg_wdata_i & CTRL_MASK;
  end

  assign reg_berr_o  = reg_sel_i && !reg_super_i;
  assign reg_rdata_o = (reg_sel_i && reg_super_i) ? ctrl_q : '0;

  always_comb begin
    pend_x[0] = 1'b0;
    for (int k = 1; k <= NUM_LVL; k++)
      pend_x[k] = (act[k-1] && ctrl_q[NUM_LVL+k])
                || (k == TIMER_LEVEL && tmr_req_i && ctrl_q[REG_W-1]);
  end

  irq_prio_enc u_enc (.req_i(pend_x), .lvl_o(ipl_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipl_q <= '0;
    else         ipl_q <= ipl_d;
  end
  assign ipl_o = ipl_q;

  assign avec_x      = {ctrl_q[NUM_LVL-1:0], 1'b0};
  assign hit         = pend_x[iack_lvl_i];
  assign av          = avec_x[iack_lvl_i];
  assign iack_done_o = iack_i && (!hit || av);
  assign iack_ext_o  = iack_i && hit && !av;

  always_comb begin
    if (!iack_i || (hit && !av)) iack_vec_o = '0;
    else if (!hit)               iack_vec_o = 8'(VEC_BASE);
    else                         iack_vec_o = 8'(VEC_BASE) + {5'b0, iack_lvl_i};
  end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int VEC_BASE = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_sel_i,
  input logic        reg_we_i,
  input logic        reg_super_i,
  input logic [15:0] reg_rdata_o,
  input logic [15:0] ctrl_q,
  input logic [6:0]  sync_q,
  input logic [7:0]  pend_x,
  input logic [7:0]  avec_x,
  input logic [2:0]  ipl_o,
  input logic        iack_i,
  input logic [2:0]  iack_lvl_i,
  input logic        iack_done_o,
  input logic        iack_ext_o,
  input logic [7:0]  iack_vec_o
);
  assert_bit7_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7] == 1'b0);

  assert_user_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && reg_we_i && !reg_super_i) |=> $stable(ctrl_q));

  assert_idle_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_x) == 8'h00) |-> (ipl_o == 3'd0));

  assert_autovec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && pend_x[iack_lvl_i] && avec_x[iack_lvl_i])
      |-> (iack_done_o && iack_vec_o == 8'(VEC_BASE) + {5'b0, iack_lvl_i}));

  assert_ext_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_ext_o |-> (!iack_done_o && iack_vec_o == 8'd0));

  assert_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && !pend_x[iack_lvl_i]) |-> (iack_done_o && !iack_ext_o && iack_vec_o == 8'(VEC_BASE)));

  assert_sync_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(iack_i) |-> $stable(sync_q));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  localparam int SYNC = 3;
  localparam int TLVL = 4;
  localparam int VB   = 24;
  localparam logic [6:0] IDLE = 7'h55;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pins = IDLE;
  logic        tmr = 1'b0;
  logic        sel = 1'b0, we = 1'b0, sup = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        berr;
  logic [2:0]  ipl;
  logic        iack = 1'b0;
  logic [2:0]  alvl = '0;
  logic        done, ext;
  logic [7:0]  vec;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  lvl_irq_ctrl #(.TIMER_LEVEL(TLVL), .SYNC_STAGES(SYNC), .VEC_BASE(VB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .tmr_req_i(tmr),
    .reg_sel_i(sel), .reg_we_i(we), .reg_super_i(sup), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_berr_o(berr), .ipl_o(ipl),
    .iack_i(iack), .iack_lvl_i(alvl), .iack_done_o(done),
    .iack_ext_o(ext), .iack_vec_o(vec)
  );

  // act, ien, avec, ack level, ipl, done, ext, vec
  localparam logic [36:0] VECS [8] = '{
    {7'b0000000, 7'h7F, 7'h7F, 3'd3, 3'd0, 1'b1, 1'b0, 8'd24},
    {7'b0000100, 7'h7F, 7'h7F, 3'd3, 3'd3, 1'b1, 1'b0, 8'd27},
    {7'b1000001, 7'h7F, 7'h7F, 3'd7, 3'd7, 1'b1, 1'b0, 8'd31},
    {7'b1000001, 7'h3F, 7'h7F, 3'd7, 3'd1, 1'b1, 1'b0, 8'd24},
    {7'b0010010, 7'h7F, 7'h6F, 3'd5, 3'd5, 1'b0, 1'b1, 8'd0},
    {7'b0010010, 7'h6F, 7'h6F, 3'd5, 3'd2, 1'b1, 1'b0, 8'd24},
    {7'b0000010, 7'h7F, 7'h7F, 3'd0, 3'd2, 1'b1, 1'b0, 8'd24},
    {7'b1111111, 7'h7F, 7'h00, 3'd1, 3'd7, 1'b0, 1'b1, 8'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [15:0] d);
    sel = 1'b1; we = 1'b1; sup = s; wdata = d;
    step(1);
    sel = 1'b0; we = 1'b0; sup = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] exp);
    sel = 1'b1; we = 1'b0; sup = 1'b1;
    #1 chk(tag, rdata, exp);
    sel = 1'b0; sup = 1'b0;
  endtask

  task automatic ack_chk(input string tag, input logic [2:0] l,
                         input logic d, input logic e, input logic [7:0] v);
    iack = 1'b1; alvl = l;
    #1;
    chk({tag, " done"}, {15'b0, done}, {15'b0, d});
    chk({tag, " ext"},  {15'b0, ext},  {15'b0, e});
    chk({tag, " vec"},  {8'b0, vec},   {8'b0, v});
    step(1);
    iack = 1'b0; alvl = '0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    chk("R1 ipl after reset", {13'b0, ipl}, 16'h0);
    rd_chk("R1 ctrl reset", 16'h007F);
    step(10);  // polarity learned with pins idle (R4)

    // table walk: R4 R6 R8 R9 R10
    for (int i = 0; i < 8; i++) begin
      logic [36:0] e;
      e = VECS[i];
      wr(1'b1, {1'b0, e[29:23], 1'b0, e[22:16]});
      pins = e[36:30] ^ IDLE;
      step(SYNC + 2);
      chk($sformatf("R6 R4 ipl row %0d", i), {13'b0, ipl}, {13'b0, e[12:10]});
      ack_chk($sformatf("R8 R9 R10 ack row %0d", i), e[15:13], e[9], e[8], e[7:0]);
    end

    // R4: raw low on every pin activates levels 1,3,5,7
    wr(1'b1, 16'h7F7F);
    pins = 7'h00;
    step(SYNC + 2);
    chk("R4 inverted polarity ipl", {13'b0, ipl}, 16'd7);
    pins = IDLE;
    step(SYNC + 2);
    chk("R4 idle ipl", {13'b0, ipl}, 16'd0);

    // R2: write with bit 7 set, reads 0
    wr(1'b1, 16'hA5FF);
    rd_chk("R2 write readback", 16'hA57F);

    // R3: user write ignored, berr, read zero
    sel = 1'b1; we = 1'b1; sup = 1'b0; wdata = 16'h1234;
    #1 chk("R3 berr on user write", {15'b0, berr}, 16'h1);
    chk("R3 user read zero", rdata, 16'h0);
    step(1);
    sel = 1'b0; we = 1'b0;
    #1 chk("R3 berr idle", {15'b0, berr}, 16'h0);
    rd_chk("R3 ctrl unchanged", 16'hA57F);

    // R5: latency of SYNC+1 edges
    wr(1'b1, 16'h7F7F);
    pins = IDLE ^ 7'b0100000;  // level 6
    step(SYNC);
    chk("R5 not yet", {13'b0, ipl}, 16'd0);
    step(1);
    chk("R5 arrived", {13'b0, ipl}, 16'd6);
    pins = IDLE;
    step(SYNC + 2);

    // R7: timer at level TLVL gated by bit 15
    tmr = 1'b1;
    step(2);
    chk("R7 timer disabled", {13'b0, ipl}, 16'd0);
    wr(1'b1, 16'h807F);
    step(1);
    chk("R7 timer enabled", {13'b0, ipl}, 16'd4);
    ack_chk("R7 R8 timer ack", 3'd4, 1'b1, 1'b0, 8'd28);
    pins = IDLE ^ 7'b0000100;  // level 3, disabled in ctrl
    step(SYNC + 2);
    chk("R7 timer over disabled lvl", {13'b0, ipl}, 16'd4);
    wr(1'b1, 16'h007F);
    step(1);
    chk("R7 timer off", {13'b0, ipl}, 16'd0);
    tmr = 1'b0;
    pins = IDLE;
    step(SYNC + 2);

    // R11: freeze during acknowledge
    wr(1'b1, 16'h7F7F);
    iack = 1'b1; alvl = 3'd1;
    step(1);
    pins = IDLE ^ 7'b0100000;
    step(SYNC + 4);
    chk("R11 frozen ipl", {13'b0, ipl}, 16'd0);
    iack = 1'b0; alvl = '0;
    step(SYNC + 1);
    chk("R11 released ipl", {13'b0, ipl}, 16'd6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule